// File: doc/BRIEF.md
# Short-Distance Reuse Sampling Queue

This block sits beside a per-instruction reuse-distance predictor. It catches short reuse distances that the predictor's own single outstanding sample cannot see while that sample waits on a long distance. The block watches the filtered stream of read accesses and picks about one access in 2^SAMPLE_BITS at pseudo-random. For each pick it records the block address, the index of the predictor entry that predicted for that access, and the access count at the time. The record goes into a small ring of DEPTH slots, so the longest distance the queue can observe is roughly DEPTH times the sampling period: 8 × 256 = 2048 accesses with the default parameters.

A later access to a recorded address retires that slot and produces a short-distance update, with its distance, for the linked predictor entry. A live slot that is overwritten before any access matches it produces a long-distance event for its link. Each predictor entry keeps a credit counter. A long event adds one credit, and each credit swallows one later short update, which keeps the short bias of the queue in check. The predictor table is outside the block and takes the two update outputs.

Top module: `sdf_sampler`

## Requirements
- R1: After reset every slot is empty, every credit counter is zero, the pseudo-random register holds 16'hACE1, the access counter is zero, and both update outputs are low.
- R2: The pseudo-random register is a 16-bit shift register that advances once per valid access. Its next value is {s[14:0], s[15]^s[13]^s[12]^s[10]}. An access is sampled when the register's low SAMPLE_BITS bits are zero before that access advances it. A sampled access is written into the slot at the write pointer, and the write pointer then moves to the next slot in ring order.
- R3: When a valid access matches the address of a live slot and the linked credit is zero, short_valid is high in the following cycle. short_link then carries the slot's link, and short_dist carries the current access index minus the index stored at sampling (modulo 2^STAMP_W, always at least 1).
- R4: A slot is matched at most once and becomes empty when matched. An access whose address has no live slot, because it was never sampled or was already matched, produces no short update.
- R5: When a sampled access overwrites a slot that is still live, long_valid is high in the following cycle and long_link carries the link of the overwritten slot.
- R6: Overwriting a slot that was emptied by a match, or by a match in the same cycle, produces no long update.
- R7: A long event adds one credit for its link. A match whose link has a non-zero credit produces no short update and removes one credit.
- R8: Credits saturate at 7. In a cycle that has both a block and a long event on the same link, the decrement is applied before the saturating increment.
- R9: A cycle with acc_valid low changes no state and raises no update output in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A filtered read access is present this cycle |
| acc_addr | input | ADDR_W | Block address of the access |
| acc_link | input | LINK_W | Predictor entry that predicted for this access |
| short_valid | output | 1 | A short-distance update is issued |
| short_link | output | LINK_W | Predictor entry to update with a short distance |
| short_dist | output | STAMP_W | Measured reuse distance in accesses |
| long_valid | output | 1 | A long-distance event is issued |
| long_link | output | LINK_W | Predictor entry to update with a long distance |

## Verification
A reference model of the queue runs beside the design through four stimulus mixes. Two alternating addresses give almost every sample a quick match, which exercises short distances, the once-only match and the credit blocking. A stream of never-repeating addresses has every sample age out, so the long events alone expose the sampling rule and the ring order. A 16-address pool with half the cycles idle separates the effect of the idle cycles from the effect of real accesses. A 40-address pool with mixed links drives the credits into saturation and produces cycles that hold both a match and an eviction.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

    localparam int          RNG_W    = 16;
    localparam logic [15:0] RNG_SEED = 16'hACE1;

    // Maximal-length shift step, taps at bits 15, 13, 12, 10
    function automatic logic [RNG_W-1:0] rng_step(input logic [RNG_W-1:0] s);
        return {s[RNG_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/sdf_sample_gate.sv
module sdf_sample_gate
    import sdf_pkg::*;
#(
    parameter int SAMPLE_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_valid,
    output logic take
);

    typedef struct packed {
        logic [RNG_W-1:0] rng;
    } gate_t;

    gate_t gate_q, gate_d;

    always_comb begin
        gate_d = gate_q;
        take   = acc_valid && (gate_q.rng[SAMPLE_BITS-1:0] == '0);
        if (acc_valid) begin
            gate_d.rng = rng_step(gate_q.rng);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q.rng <= RNG_SEED;
        end else begin
            gate_q <= gate_d;
        end
    end

endmodule

// File: rtl/sdf_ring.sv
module sdf_ring #(
    parameter int ADDR_W  = 32,
    parameter int LINK_W  = 8,
    parameter int DEPTH   = 8,
    parameter int STAMP_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [LINK_W-1:0]  acc_link,
    input  logic               take,
    output logic               hit,
    output logic [LINK_W-1:0]  hit_link,
    output logic [STAMP_W-1:0] hit_dist,
    output logic               drop_live,
    output logic [LINK_W-1:0]  drop_link
);

    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0]              live;
        logic [DEPTH-1:0][ADDR_W-1:0]  addr;
        logic [DEPTH-1:0][LINK_W-1:0]  link;
        logic [DEPTH-1:0][STAMP_W-1:0] stamp;
        logic [PTR_W-1:0]              wr;
        logic [STAMP_W-1:0]            now;
    } ring_t;

    ring_t            ring_q, ring_d;
    logic [PTR_W-1:0] hit_idx;

    always_comb begin
        ring_d    = ring_q;
        hit       = 1'b0;
        hit_idx   = '0;
        hit_link  = '0;
        hit_dist  = '0;
        drop_live = 1'b0;
        drop_link = '0;
        if (acc_valid) begin
            // at most one live slot can hold a given address
            for (int i = 0; i < DEPTH; i++) begin
                if (!hit && ring_q.live[i] && ring_q.addr[i] == acc_addr) begin
                    hit     = 1'b1;
                    hit_idx = PTR_W'(i);
                end
            end
            if (hit) begin
                hit_link              = ring_q.link[hit_idx];
                hit_dist              = ring_q.now - ring_q.stamp[hit_idx];
                ring_d.live[hit_idx]  = 1'b0;
            end
            if (take) begin
                drop_live                = ring_d.live[ring_q.wr];
                drop_link                = ring_q.link[ring_q.wr];
                ring_d.live[ring_q.wr]   = 1'b1;
                ring_d.addr[ring_q.wr]   = acc_addr;
                ring_d.link[ring_q.wr]   = acc_link;
                ring_d.stamp[ring_q.wr]  = ring_q.now;
                ring_d.wr                = ring_q.wr + 1'b1;
            end
            ring_d.now = ring_q.now + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

endmodule

// File: rtl/sdf_tally.sv
module sdf_tally #(
    parameter int LINK_W = 8,
    parameter int CRED_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [LINK_W-1:0] hit_link,
    input  logic              drop_live,
    input  logic [LINK_W-1:0] drop_link,
    output logic              pass
);

    localparam int                NLINK    = 1 << LINK_W;
    localparam logic [CRED_W-1:0] CRED_MAX = {CRED_W{1'b1}};

    typedef struct packed {
        logic [NLINK-1:0][CRED_W-1:0] cred;
    } tally_t;

    tally_t tally_q, tally_d;

    always_comb begin
        tally_d = tally_q;
        pass    = 1'b0;
        if (hit) begin
            if (tally_q.cred[hit_link] == '0) begin
                pass = 1'b1;
            end else begin
                tally_d.cred[hit_link] = tally_q.cred[hit_link] - 1'b1;
            end
        end
        // decrement above first, then the saturating increment
        if (drop_live && tally_d.cred[drop_link] != CRED_MAX) begin
            tally_d.cred[drop_link] = tally_d.cred[drop_link] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tally_q <= '0;
        end else begin
            tally_q <= tally_d;
        end
    end

endmodule

// File: rtl/sdf_sampler.sv
module sdf_sampler #(
    parameter int ADDR_W      = 32,
    parameter int LINK_W      = 8,
    parameter int DEPTH       = 8,
    parameter int SAMPLE_BITS = 8,
    parameter int STAMP_W     = 16,
    parameter int CRED_W      = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [LINK_W-1:0]  acc_link,
    output logic               short_valid,
    output logic [LINK_W-1:0]  short_link,
    output logic [STAMP_W-1:0] short_dist,
    output logic               long_valid,
    output logic [LINK_W-1:0]  long_link
);

    typedef struct packed {
        logic               sv;
        logic [LINK_W-1:0]  sl;
        logic [STAMP_W-1:0] sd;
        logic               lv;
        logic [LINK_W-1:0]  ll;
    } out_t;

    logic               take;
    logic               hit;
    logic [LINK_W-1:0]  hit_link;
    logic [STAMP_W-1:0] hit_dist;
    logic               drop_live;
    logic [LINK_W-1:0]  drop_link;
    logic               pass;
    out_t               out_q, out_d;

    sdf_sample_gate #(.SAMPLE_BITS(SAMPLE_BITS)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .take      (take)
    );

    sdf_ring #(
        .ADDR_W  (ADDR_W),
        .LINK_W  (LINK_W),
        .DEPTH   (DEPTH),
        .STAMP_W (STAMP_W)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_link  (acc_link),
        .take      (take),
        .hit       (hit),
        .hit_link  (hit_link),
        .hit_dist  (hit_dist),
        .drop_live (drop_live),
        .drop_link (drop_link)
    );

    sdf_tally #(.LINK_W(LINK_W), .CRED_W(CRED_W)) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .hit_link  (hit_link),
        .drop_live (drop_live),
        .drop_link (drop_link),
        .pass      (pass)
    );

    always_comb begin
        out_d    = '0;
        out_d.sv = pass;
        out_d.sl = pass ? hit_link : '0;
        out_d.sd = pass ? hit_dist : '0;
        out_d.lv = drop_live;
        out_d.ll = drop_live ? drop_link : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign short_valid = out_q.sv;
    assign short_link  = out_q.sl;
    assign short_dist  = out_q.sd;
    assign long_valid  = out_q.lv;
    assign long_link   = out_q.ll;

endmodule

// File: rtl/sdf_sampler_chk.sv
module sdf_sampler_chk #(
    parameter int STAMP_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic               short_valid,
    input logic [STAMP_W-1:0] short_dist,
    input logic               long_valid
);

    // R3: a short update always follows an access
    assert_short_after_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !short_valid);

    // R3: a reported distance is never zero
    assert_dist_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        short_valid |-> short_dist != '0);

    // R5: a long event always follows an access
    assert_long_after_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !long_valid);

    // R9: an idle cycle leaves both outputs low
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !(short_valid || long_valid));

endmodule

bind sdf_sampler sdf_sampler_chk #(.STAMP_W(STAMP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .short_valid (short_valid),
    .short_dist  (short_dist),
    .long_valid  (long_valid)
);

// File: tb/sim_sdf_sampler.sv
`timescale 1ns/1ps
module sim_sdf_sampler;

    localparam int AW = 8;
    localparam int LW = 3;
    localparam int DP = 4;
    localparam int SB = 2;
    localparam int TW = 16;
    localparam int NL = 1 << LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [LW-1:0] acc_link = '0;
    logic          short_valid;
    logic [LW-1:0] short_link;
    logic [TW-1:0] short_dist;
    logic          long_valid;
    logic [LW-1:0] long_link;

    always #2.5 clk = ~clk;

    sdf_sampler #(
        .ADDR_W(AW), .LINK_W(LW), .DEPTH(DP),
        .SAMPLE_BITS(SB), .STAMP_W(TW), .CRED_W(3)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_link(acc_link),
        .short_valid(short_valid), .short_link(short_link), .short_dist(short_dist),
        .long_valid(long_valid), .long_link(long_link)
    );

    int total = 0;
    int fails = 0;

    // reference model state
    logic          m_live [DP];
    logic          m_used [DP];
    logic [AW-1:0] m_addr [DP];
    logic [LW-1:0] m_link [DP];
    logic [TW-1:0] m_stamp[DP];
    int            m_wr;
    logic [TW-1:0] m_now;
    logic [15:0]   m_rng;
    int            m_cred [NL];
    bit            m_clip [NL];

    logic          e_sv, e_lv;
    logic [LW-1:0] e_sl, e_ll;
    logic [TW-1:0] e_sd;
    string         s_tag, l_tag;
    bit            have_exp;
    bit            fresh_mode;
    int            fresh_ctr;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < DP; i++) begin
            m_live[i] = 0; m_used[i] = 0; m_addr[i] = '0; m_link[i] = '0; m_stamp[i] = '0;
        end
        for (int j = 0; j < NL; j++) begin
            m_cred[j] = 0; m_clip[j] = 0;
        end
        m_wr = 0; m_now = '0; m_rng = 16'hACE1;
    endtask

    task automatic model_step(bit v, logic [AW-1:0] a, logic [LW-1:0] l);
        bit hit;
        int idx;
        logic [LW-1:0] hl;
        e_sv = 0; e_sl = '0; e_sd = '0; e_lv = 0; e_ll = '0;
        s_tag = "R9"; l_tag = "R9";
        if (v) begin
            hit = 0; idx = 0;
            for (int i = 0; i < DP; i++) begin
                if (!hit && m_live[i] && m_addr[i] == a) begin hit = 1; idx = i; end
            end
            s_tag = "R4";
            if (hit) begin
                hl = m_link[idx];
                m_live[idx] = 0;
                if (m_cred[hl] != 0) begin
                    m_cred[hl]--;
                    s_tag = "R7";
                end else begin
                    e_sv = 1; e_sl = hl; e_sd = m_now - m_stamp[idx];
                    s_tag = m_clip[hl] ? "R8" : "R3";
                end
            end
            l_tag = "R5";
            if (m_rng[SB-1:0] == '0) begin
                if (m_live[m_wr]) begin
                    e_lv = 1; e_ll = m_link[m_wr];
                    if (m_cred[e_ll] == 7) m_clip[e_ll] = 1;
                    else m_cred[e_ll]++;
                end else if (m_used[m_wr]) begin
                    l_tag = "R6";
                end
                m_live[m_wr] = 1; m_used[m_wr] = 1;
                m_addr[m_wr] = a; m_link[m_wr] = l; m_stamp[m_wr] = m_now;
                m_wr = (m_wr + 1) % DP;
            end
            if (fresh_mode) l_tag = "R2";
            m_rng = {m_rng[14:0], m_rng[15] ^ m_rng[13] ^ m_rng[12] ^ m_rng[10]};
            m_now = m_now + 1'b1;
        end
    endtask

    task automatic compare_outputs();
        check(s_tag, "short", {12'h0, short_valid, short_link, short_dist},
                              {12'h0, e_sv, e_sl, e_sd});
        check(l_tag, "long", {28'h0, long_valid, long_link}, {28'h0, e_lv, e_ll});
    endtask

    task automatic run_phase(int cycles, int pool, int pct_valid, bit fresh);
        bit v;
        logic [AW-1:0] a;
        logic [LW-1:0] l;
        fresh_mode = fresh;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (have_exp) compare_outputs();
            v = ($urandom_range(99) < pct_valid);
            if (fresh) begin
                a = AW'(fresh_ctr);
                fresh_ctr++;
            end else begin
                a = AW'($urandom_range(pool - 1));
            end
            l = LW'($urandom_range(NL - 1));
            model_step(v, a, l);
            acc_valid = v; acc_addr = a; acc_link = l;
            have_exp = 1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        model_reset();
        have_exp = 0; fresh_mode = 0; fresh_ctr = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs quiet after reset
        check("R1", "short_valid", {31'h0, short_valid}, 32'h0);
        check("R1", "long_valid", {31'h0, long_valid}, 32'h0);
        // two alternating addresses: quick matches, blocking
        run_phase(3000, 2, 100, 0);
        // never-repeating addresses: every sample ages out
        run_phase(3000, 1, 100, 1);
        // idle cycles mixed in
        run_phase(3000, 16, 50, 0);
        // wide pool: saturation and same-cycle events
        run_phase(6000, 40, 80, 0);
        // drain with idle cycles
        run_phase(4, 1, 0, 0);
        @(negedge clk);
        compare_outputs();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule